// File: doc/BRIEF.md
# SDRAM Refresh Interval Generator

This block paces the periodic refresh of an SDRAM array. A two-bit rate code picks one of three refresh periods (7.8 us, 15.6 us or 125 us) or turns refresh off. A two-bit clock select states which bus clock the controller runs on: 66, 100 or 133 MHz. From these two codes the block derives a terminal count in controller cycles. It counts up to it and then raises a refresh request for the memory sequencer.

The request stays high until the sequencer acknowledges it. The accepted acknowledge restarts the interval. If a whole further interval expires while a request is still waiting, a sticky missed-refresh flag is set, so the controller can report that the array may have lost data. The block has no data stream. All of its pins are plain level-sensitive control and status signals, so there is no back-pressure to manage. The request/acknowledge pair is a simple level handshake.

Top module: `refresh_interval_gen`

## Requirements
- R1: Rate code 2'b00 disables refresh. While it is applied, `refresh_req` is low from the next cycle on, and any pending request is dropped.
- R2: Rate code 2'b01 selects a period of 7.8 us (78 tenths of a microsecond by default).
- R3: Rate code 2'b10 selects a period of 15.6 us (156 tenths by default).
- R4: Rate code 2'b11 selects a period of 125 us (1250 tenths by default).
- R5: Clock select 2'b00 means 66 MHz, 2'b01 means 100 MHz and 2'b10 means 133 MHz. Code 2'b11 uses the 66 MHz counts. The terminal count TC is floor(tenths × MHz / 10); for example, 780 cycles for 7.8 us at 100 MHz.
- R6: After a restart edge, `refresh_req` rises on the TC-th clock edge that follows. It then stays high until `refresh_ack` is sampled high.
- R7: When `refresh_ack` is sampled high while a request is pending, the request is low in the next cycle. The count restarts from zero at that edge, so the next request rises TC edges later.
- R8: If the interval expires again while a request is pending and no acknowledge is taken on that edge, `refresh_missed` goes high. It then stays high until reset.
- R9: A change of the rate code or the clock select restarts the count from zero at the edge where the change is first sampled. A request that is already pending is kept.
- R10: After reset, `refresh_req` and `refresh_missed` are low. The first edge that samples a non-zero rate code is a restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_code | input | 2 | Refresh period select (00 selects off) |
| clk_sel | input | 2 | Bus clock frequency select |
| refresh_ack | input | 1 | Sequencer accepts the pending refresh |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| refresh_missed | output | 1 | Sticky flag: an interval expired with a request still pending |

## Verification
Every result here is a count of clock edges from a restart edge: either the edge that first samples a new configuration or an accepted acknowledge. The request is due on edge TC after that restart, and the missed flag is due TC edges after the request rose. Dropping the request after an acknowledge or a disable takes exactly one edge. The bench drives inputs on falling edges and counts falling edges from the stimulus. It checks that each output is still low at TC edges and high at TC+1 edges, so both an early and a late output are caught.

// File: rtl/refresh_interval_pkg.sv
package refresh_interval_pkg;

  // Cycles that fit in a period given in tenths of a microsecond, rounded down
  function automatic int period_cycles(input int tenths_us, input int mhz);
    return (tenths_us * mhz) / 10;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/refresh_tc_select.sv
module refresh_tc_select #(
  parameter int CNT_W    = 15,
  parameter int MHZ_SLOW = 66,
  parameter int MHZ_MID  = 100,
  parameter int MHZ_FAST = 133,
  parameter int T_SHORT  = 78,
  parameter int T_MID    = 156,
  parameter int T_LONG   = 1250
) (
  input  logic [1:0]       rate_code,
  input  logic [1:0]       clk_sel,
  output logic [CNT_W-1:0] term_count
);
  import refresh_interval_pkg::*;

  localparam int FREQ_OF [4] = '{MHZ_SLOW, MHZ_MID, MHZ_FAST, MHZ_SLOW};
  localparam int TENTHS_OF [4] = '{0, T_SHORT, T_MID, T_LONG};

  logic [CNT_W-1:0] tc_tbl [16];

  for (genvar f = 0; f < 4; f++) begin : g_freq
    for (genvar r = 0; r < 4; r++) begin : g_rate
      assign tc_tbl[f*4 + r] = CNT_W'(period_cycles(TENTHS_OF[r], FREQ_OF[f]));
    end
  end

  assign term_count = tc_tbl[{clk_sel, rate_code}];
endmodule

// File: rtl/refresh_interval_counter.sv
module refresh_interval_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] term_count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = enable && !restart && (cnt_q == term_count - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !enable || restart || expire) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_req_ctl.sv
module refresh_req_ctl (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic expire,
  input  logic ack,
  output logic req,
  output logic missed,
  output logic accepted
);
  assign accepted = req && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      missed <= 1'b0;
    end else begin
      if (!enable)       req <= 1'b0;
      else if (accepted) req <= 1'b0;
      else if (expire) begin
        req <= 1'b1;
        if (req) missed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/refresh_interval_gen.sv
module refresh_interval_gen #(
  parameter int MHZ_SLOW = 66,
  parameter int MHZ_MID  = 100,
  parameter int MHZ_FAST = 133,
  parameter int T_SHORT  = 78,
  parameter int T_MID    = 156,
  parameter int T_LONG   = 1250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_code,
  input  logic [1:0] clk_sel,
  input  logic       refresh_ack,
  output logic       refresh_req,
  output logic       refresh_missed
);
  import refresh_interval_pkg::*;

  localparam int MAX_T   = max3(T_SHORT, T_MID, T_LONG);
  localparam int MAX_F   = max3(MHZ_SLOW, MHZ_MID, MHZ_FAST);
  localparam int MAX_CNT = period_cycles(MAX_T, MAX_F);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [1:0]       rate_q, sel_q;
  logic             cfg_change, enable, expire, accepted, restart;
  logic [CNT_W-1:0] tc;

  // Configuration seen last edge; a difference forces a fresh interval
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= 2'b00;
      sel_q  <= 2'b00;
    end else begin
      rate_q <= rate_code;
      sel_q  <= clk_sel;
    end
  end

  assign cfg_change = (rate_code != rate_q) || (clk_sel != sel_q);
  assign enable     = (rate_code != 2'b00);
  assign restart    = cfg_change || accepted;

  refresh_tc_select #(
    .CNT_W(CNT_W), .MHZ_SLOW(MHZ_SLOW), .MHZ_MID(MHZ_MID), .MHZ_FAST(MHZ_FAST),
    .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG)
  ) u_tc (
    .rate_code (rate_code),
    .clk_sel   (clk_sel),
    .term_count(tc)
  );

  refresh_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .restart   (restart),
    .term_count(tc),
    .expire    (expire)
  );

  refresh_req_ctl u_req (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .expire  (expire),
    .ack     (refresh_ack),
    .req     (refresh_req),
    .missed  (refresh_missed),
    .accepted(accepted)
  );
endmodule

// File: rtl/refresh_interval_gen_chk.sv
module refresh_interval_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] rate_code,
  input logic       refresh_ack,
  input logic       refresh_req,
  input logic       refresh_missed
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rate_code == 2'b00) |=> !refresh_req); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !refresh_ack && rate_code != 2'b00) |=> refresh_req); // R6
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && refresh_ack) |=> !refresh_req); // R7
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
    refresh_missed |=> refresh_missed); // R8
  AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_missed) |-> $past(refresh_req)); // R8
  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_req) |-> $past(rate_code != 2'b00)); // R1
endmodule

bind refresh_interval_gen refresh_interval_gen_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .rate_code     (rate_code),
  .refresh_ack   (refresh_ack),
  .refresh_req   (refresh_req),
  .refresh_missed(refresh_missed)
);

// File: tb/refresh_interval_gen_test.sv
module refresh_interval_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int F0 = 66, F1 = 100, F2 = 133;
  localparam int TS = 2, TM = 4, TL = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_code = 2'b00;
  logic [1:0] clk_sel = 2'b00;
  logic       refresh_ack = 1'b0;
  logic       refresh_req, refresh_missed;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_interval_gen #(
    .MHZ_SLOW(F0), .MHZ_MID(F1), .MHZ_FAST(F2),
    .T_SHORT(TS), .T_MID(TM), .T_LONG(TL)
  ) uut (
    .clk(clk), .rst(rst), .rate_code(rate_code), .clk_sel(clk_sel),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req),
    .refresh_missed(refresh_missed)
  );

  function automatic int exp_tc(input logic [1:0] r, input logic [1:0] s);
    int f, t;
    f = (s == 2'd1) ? F1 : (s == 2'd2) ? F2 : F0;
    t = (r == 2'd1) ? TS : (r == 2'd2) ? TM : (r == 2'd3) ? TL : 0;
    return (t * f) / 10;
  endfunction

  task automatic check(input string tag, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; rate_code = 2'b00; refresh_ack = 1'b0;
    wait_n(2);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R10 req after reset", refresh_req, 1'b0);
    check("R10 missed after reset", refresh_missed, 1'b0);

    // Sweep every clock select and every enabled rate code
    for (int s = 0; s < 4; s++) begin
      for (int r = 1; r < 4; r++) begin
        int tc;
        tc = exp_tc(2'(r), 2'(s));
        do_reset();
        clk_sel = 2'(s); rate_code = 2'(r);
        wait_n(tc);
        check($sformatf("R2 R3 R4 R5 R6 early s=%0d r=%0d", s, r), refresh_req, 1'b0);
        wait_n(1);
        check($sformatf("R2 R3 R4 R5 R6 due s=%0d r=%0d", s, r), refresh_req, 1'b1);
        wait_n(tc - 1);
        check("R6 held without ack", refresh_req, 1'b1);
        check("R8 missed early", refresh_missed, 1'b0);
        wait_n(1);
        check("R8 missed due", refresh_missed, 1'b1);
        refresh_ack = 1'b1;
        wait_n(1);
        refresh_ack = 1'b0;
        check("R7 req dropped", refresh_req, 1'b0);
        check("R8 missed sticky", refresh_missed, 1'b1);
        wait_n(tc - 1);
        check("R7 next early", refresh_req, 1'b0);
        wait_n(1);
        check("R7 next due", refresh_req, 1'b1);
      end
    end

    // R9: change rate mid-interval restarts the count
    do_reset();
    clk_sel = 2'd1; rate_code = 2'd3;
    wait_n(exp_tc(2'd3, 2'd1) / 2);
    rate_code = 2'd1;
    wait_n(exp_tc(2'd1, 2'd1));
    check("R9 rate change early", refresh_req, 1'b0);
    wait_n(1);
    check("R9 rate change due", refresh_req, 1'b1);
    // R9: change clock select keeps pending request, restarts count
    clk_sel = 2'd2;
    wait_n(1);
    check("R9 pending kept", refresh_req, 1'b1);
    wait_n(exp_tc(2'd1, 2'd2) - 1);
    check("R9 sel change no miss early", refresh_missed, 1'b0);
    wait_n(1);
    check("R9 sel change miss due", refresh_missed, 1'b1);

    // R1: disable drops a pending request and stays quiet
    rate_code = 2'd0;
    wait_n(1);
    check("R1 pending dropped", refresh_req, 1'b0);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 300; i++) begin
        wait_n(1);
        if (refresh_req) seen = 1'b1;
      end
      check("R1 no request while off", seen, 1'b0);
    end
    check("R8 sticky while off", refresh_missed, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule